// File: doc/BRIEF.md
# Four-Phase Frame Sequencer

Each replica of a redundant control computer runs this sequencer to pace its work frame by frame. A frame is split into four phases that always come in the same order: compute, broadcast, vote and sync. The three timed phases each last a programmed number of local clock ticks. The sync phase lasts until the clock-synchronisation hardware reports that it has finished resynchronising. A frame counter advances once per frame. The block emits a one-cycle strobe at the start of compute, a second when the outgoing mailbox is to be loaded, a third when voting and state replacement begin, and a level request that holds for the whole sync phase.

Alongside the phase sequence, the block produces an enable for each task slot. Each slot has its own rate n, so a slot can run every frame, every second frame, and so on. All configuration is captured in one atomic step at the point where a frame begins. A new duration or rate therefore never takes effect partway through a frame. When the broadcast window is configured shorter than the worst-case delivery delay plus the worst-case skew between replicas, the block raises an error flag.

Top module: `frame_sequencer`

## Requirements
- R1: The phase output, encoded compute=0, broadcast=1, vote=2, sync=3, only ever moves from 0 to 1, from 1 to 2, from 2 to 3, or from 3 back to 0.
- R2: While reset is held and in the first cycle after it is released, the phase is compute and the frame number is zero. All strobes, every task enable, the resync request and the error flag are low.
- R3: The frame number goes up by one (wrapping at its width) on the clock edge that leaves sync for compute. It holds its value on every other edge.
- R4: Compute, broadcast and vote each end on the clock edge that accepts their Nth tick. N is the captured length for that phase, and a length of zero behaves as one. A tick is accepted only on an edge taken in that phase. The first edge after reset accepts no tick.
- R5: Sync lasts until an edge on which syncDone is high. The resync request is high exactly while the phase is sync. syncDone has no effect in any other phase.
- R6: The error flag is high for a frame exactly when that frame's captured broadcast length is strictly below captured maxDelay + maxSkew. The sum is taken without overflow.
- R7: Task slot k, whose rate is in cfgRates bits [4k+3:4k], is enabled only while the phase is compute. It is enabled exactly in frames whose number is a multiple of its rate.
- R8: computeStart is high for one cycle, in the first cycle of each compute phase. mailboxLoad is high for one cycle, in the first cycle of broadcast. voteStart is high for one cycle, in the first cycle of vote.
- R9: Lengths, rates, maxDelay and maxSkew are captured on the first edge after reset and on each edge that leaves sync. Changing these inputs at any other time has no effect until the next capture.
- R10: A task slot whose rate is zero is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Local clock tick enable |
| syncDone | input | 1 | Resynchronisation finished |
| cfgComputeLen | input | CNT_W | Compute length in ticks |
| cfgBcastLen | input | CNT_W | Broadcast length in ticks |
| cfgVoteLen | input | CNT_W | Vote length in ticks |
| cfgMaxDelay | input | CNT_W | Worst-case message delivery delay |
| cfgMaxSkew | input | CNT_W | Worst-case inter-replica skew |
| cfgRates | input | NUM_TASKS*RATE_W | Per-slot frame rate, slot k at bits [k*RATE_W +: RATE_W] |
| phase | output | 2 | Current phase |
| frameNum | output | FRAME_W | Frame counter |
| computeStart | output | 1 | Compute start strobe |
| mailboxLoad | output | 1 | Load outgoing mailbox strobe |
| voteStart | output | 1 | Start vote and replace state strobe |
| resyncReq | output | 1 | Clock resync request |
| taskEn | output | NUM_TASKS | Per-slot run enables |
| cfgError | output | 1 | Broadcast window too short |

## Verification
The properties assume that tick and syncDone are synchronous to clk and can take any value on any cycle, including syncDone outside the sync phase. They also assume that the configuration inputs can change at any time. The stimulus drives every input away from the active edge. It draws tick and syncDone from a random source so that syncDone is often high outside sync. It changes the lengths and rates in the middle of frames, including one change in the middle of compute. One configuration puts the broadcast length below the bound and another sets it exactly equal to the bound, so both sides of the error comparison are exercised.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_COMPUTE = 2'd0,
    PH_BCAST   = 2'd1,
    PH_VOTE    = 2'd2,
    PH_SYNC    = 2'd3
  } phase_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic cfgLoad;   // capture configuration this edge
    logic frameInc;  // leaving sync: advance frame
    logic inCompute; // current phase is compute
  } seq_ctl_s;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             syncDone,
  input  logic [CNT_W-1:0] lenCompute,
  input  logic [CNT_W-1:0] lenBcast,
  input  logic [CNT_W-1:0] lenVote,
  output phase_e           phaseQ,
  output logic             computeStart,
  output logic             mailboxLoad,
  output logic             voteStart,
  output seq_ctl_s         ctl
);
  logic             primedQ;
  logic [CNT_W-1:0] tickCntQ;
  logic [CNT_W-1:0] lenCur;
  logic [CNT_W:0]   cntPlus;
  logic             lastTick;
  logic             syncExit;
  logic             timedAdvance;
  phase_e           phaseNext;

  always_comb begin
    case (phaseQ)
      PH_COMPUTE: lenCur = lenCompute;
      PH_BCAST:   lenCur = lenBcast;
      PH_VOTE:    lenCur = lenVote;
      default:    lenCur = '0;
    endcase
  end

  // a programmed length of zero still needs one accepted tick
  assign cntPlus      = {1'b0, tickCntQ} + 1'b1;
  assign lastTick     = tick && (cntPlus >= {1'b0, lenCur});
  assign syncExit     = primedQ && (phaseQ == PH_SYNC) && syncDone;
  assign timedAdvance = primedQ && (phaseQ != PH_SYNC) && lastTick;
  assign phaseNext    = phase_e'(phaseQ + 2'd1);

  assign ctl.cfgLoad   = !primedQ || syncExit;
  assign ctl.frameInc  = syncExit;
  assign ctl.inCompute = (phaseQ == PH_COMPUTE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ       <= PH_COMPUTE;
      primedQ      <= 1'b0;
      tickCntQ     <= '0;
      computeStart <= 1'b0;
      mailboxLoad  <= 1'b0;
      voteStart    <= 1'b0;
    end else begin
      computeStart <= 1'b0;
      mailboxLoad  <= 1'b0;
      voteStart    <= 1'b0;
      if (!primedQ) begin
        primedQ      <= 1'b1;
        tickCntQ     <= '0;
        computeStart <= 1'b1;
      end else if (syncExit) begin
        phaseQ       <= PH_COMPUTE;
        tickCntQ     <= '0;
        computeStart <= 1'b1;
      end else if (timedAdvance) begin
        phaseQ      <= phaseNext;
        tickCntQ    <= '0;
        mailboxLoad <= (phaseQ == PH_COMPUTE);
        voteStart   <= (phaseQ == PH_BCAST);
      end else if (tick && phaseQ != PH_SYNC) begin
        tickCntQ <= cntPlus[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FRAME_W   = 16,
  parameter int NUM_TASKS = 4,
  parameter int RATE_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seq_ctl_s                    ctl,
  input  logic [CNT_W-1:0]            cfgComputeLen,
  input  logic [CNT_W-1:0]            cfgBcastLen,
  input  logic [CNT_W-1:0]            cfgVoteLen,
  input  logic [CNT_W-1:0]            cfgMaxDelay,
  input  logic [CNT_W-1:0]            cfgMaxSkew,
  input  logic [NUM_TASKS*RATE_W-1:0] cfgRates,
  output logic [CNT_W-1:0]            lenCompute,
  output logic [CNT_W-1:0]            lenBcast,
  output logic [CNT_W-1:0]            lenVote,
  output logic [FRAME_W-1:0]          frameQ,
  output logic [NUM_TASKS-1:0]        taskEn,
  output logic                        cfgError
);
  localparam int PAD_W = FRAME_W - RATE_W;

  logic [FRAME_W-1:0]   frameNext;
  logic [CNT_W:0]       bcastBound;
  logic [NUM_TASKS-1:0] slotDue;
  logic [NUM_TASKS-1:0] slotDueQ;

  assign frameNext  = ctl.frameInc ? frameQ + 1'b1 : frameQ;
  assign bcastBound = {1'b0, cfgMaxDelay} + {1'b0, cfgMaxSkew};

  for (genvar k = 0; k < NUM_TASKS; k++) begin : g_slot
    logic [RATE_W-1:0]  rate;
    logic [RATE_W-1:0]  divisor;
    logic [FRAME_W-1:0] remainder;
    assign rate       = cfgRates[k*RATE_W +: RATE_W];
    assign divisor    = (rate == '0) ? RATE_W'(1) : rate;
    assign remainder  = frameNext % {{PAD_W{1'b0}}, divisor};
    assign slotDue[k] = (rate != '0) && (remainder == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ     <= '0;
      lenCompute <= '0;
      lenBcast   <= '0;
      lenVote    <= '0;
      slotDueQ   <= '0;
      cfgError   <= 1'b0;
    end else if (ctl.cfgLoad) begin
      frameQ     <= frameNext;
      lenCompute <= cfgComputeLen;
      lenBcast   <= cfgBcastLen;
      lenVote    <= cfgVoteLen;
      slotDueQ   <= slotDue;
      cfgError   <= ({1'b0, cfgBcastLen} < bcastBound);
    end
  end

  assign taskEn = slotDueQ & {NUM_TASKS{ctl.inCompute}};
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FRAME_W   = 16,
  parameter int NUM_TASKS = 4,
  parameter int RATE_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  logic                        syncDone,
  input  logic [CNT_W-1:0]            cfgComputeLen,
  input  logic [CNT_W-1:0]            cfgBcastLen,
  input  logic [CNT_W-1:0]            cfgVoteLen,
  input  logic [CNT_W-1:0]            cfgMaxDelay,
  input  logic [CNT_W-1:0]            cfgMaxSkew,
  input  logic [NUM_TASKS*RATE_W-1:0] cfgRates,
  output logic [1:0]                  phase,
  output logic [FRAME_W-1:0]          frameNum,
  output logic                        computeStart,
  output logic                        mailboxLoad,
  output logic                        voteStart,
  output logic                        resyncReq,
  output logic [NUM_TASKS-1:0]        taskEn,
  output logic                        cfgError
);
  phase_e           phaseQ;
  seq_ctl_s         ctl;
  logic [CNT_W-1:0] lenCompute;
  logic [CNT_W-1:0] lenBcast;
  logic [CNT_W-1:0] lenVote;

  seq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .syncDone(syncDone),
    .lenCompute(lenCompute), .lenBcast(lenBcast), .lenVote(lenVote),
    .phaseQ(phaseQ), .computeStart(computeStart),
    .mailboxLoad(mailboxLoad), .voteStart(voteStart), .ctl(ctl)
  );

  seq_datapath #(
    .CNT_W(CNT_W), .FRAME_W(FRAME_W),
    .NUM_TASKS(NUM_TASKS), .RATE_W(RATE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cfgComputeLen(cfgComputeLen), .cfgBcastLen(cfgBcastLen),
    .cfgVoteLen(cfgVoteLen), .cfgMaxDelay(cfgMaxDelay),
    .cfgMaxSkew(cfgMaxSkew), .cfgRates(cfgRates),
    .lenCompute(lenCompute), .lenBcast(lenBcast), .lenVote(lenVote),
    .frameQ(frameNum), .taskEn(taskEn), .cfgError(cfgError)
  );

  assign phase     = phaseQ;
  assign resyncReq = (phaseQ == PH_SYNC);
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int FRAME_W   = 16,
  parameter int NUM_TASKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic                 syncDone,
  input logic [1:0]           phase,
  input logic [FRAME_W-1:0]   frameNum,
  input logic                 mailboxLoad,
  input logic                 voteStart,
  input logic [NUM_TASKS-1:0] taskEn
);
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> (phase == 2'($past(phase) + 2'd1))); // R1

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (frameNum != $past(frameNum)) |-> ($past(phase) == 2'd3 && phase == 2'd0)); // R3

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 2'd3 && phase == 2'd0) |-> (frameNum == FRAME_W'($past(frameNum) + 1'b1))); // R3

  AST_TICK_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase) && $past(phase) != 2'd3) |-> $past(tick)); // R4

  AST_SYNC_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && !syncDone) |=> (phase == 2'd3)); // R5

  AST_TASK_IN_COMPUTE: assert property (@(posedge clk) disable iff (!rstN)
    (taskEn != '0) |-> (phase == 2'd0)); // R7

  AST_MBX_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    mailboxLoad |-> (phase == 2'd1 && $past(phase) == 2'd0)); // R8

  AST_VOTE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    voteStart |-> (phase == 2'd2 && $past(phase) == 2'd1)); // R8
endmodule

bind frame_sequencer seq_checker #(.FRAME_W(FRAME_W), .NUM_TASKS(NUM_TASKS)) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .syncDone(syncDone), .phase(phase),
  .frameNum(frameNum), .mailboxLoad(mailboxLoad), .voteStart(voteStart),
  .taskEn(taskEn)
);

// File: tb/tb_frame_sequencer.sv
module tb_frame_sequencer;
  localparam int CNT_W = 8, FRAME_W = 16, NUM_TASKS = 4, RATE_W = 4;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1, syncDone = 1'b0;
  logic [CNT_W-1:0] cfgComputeLen, cfgBcastLen, cfgVoteLen, cfgMaxDelay, cfgMaxSkew;
  logic [NUM_TASKS*RATE_W-1:0] cfgRates;
  logic [1:0] phase;
  logic [FRAME_W-1:0] frameNum;
  logic computeStart, mailboxLoad, voteStart, resyncReq, cfgError;
  logic [NUM_TASKS-1:0] taskEn;

  int total = 0, bad = 0, cycles = 0;
  bit randTick = 0, done = 0, slot3Seen = 0;

  // reference model state
  int mPhase, mCnt, mFrame, mLc, mLb, mLv;
  int mRate[NUM_TASKS];
  bit mEn[NUM_TASKS];
  bit mPrimed, mErr, mCs, mMb, mVs;

  always #4 clk = ~clk;

  frame_sequencer #(.CNT_W(CNT_W), .FRAME_W(FRAME_W), .NUM_TASKS(NUM_TASKS), .RATE_W(RATE_W)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .syncDone(syncDone),
    .cfgComputeLen(cfgComputeLen), .cfgBcastLen(cfgBcastLen), .cfgVoteLen(cfgVoteLen),
    .cfgMaxDelay(cfgMaxDelay), .cfgMaxSkew(cfgMaxSkew), .cfgRates(cfgRates),
    .phase(phase), .frameNum(frameNum), .computeStart(computeStart),
    .mailboxLoad(mailboxLoad), .voteStart(voteStart), .resyncReq(resyncReq),
    .taskEn(taskEn), .cfgError(cfgError)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic modelLoad();
    mLc = cfgComputeLen; mLb = cfgBcastLen; mLv = cfgVoteLen;
    mErr = (int'(cfgBcastLen) < int'(cfgMaxDelay) + int'(cfgMaxSkew));
    for (int k = 0; k < NUM_TASKS; k++) begin
      mRate[k] = int'(cfgRates[k*RATE_W +: RATE_W]);
      mEn[k] = (mRate[k] != 0) && ((mFrame % mRate[k]) == 0);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mFrame = 0; mPrimed = 0; mErr = 0;
      mCs = 0; mMb = 0; mVs = 0;
      for (int k = 0; k < NUM_TASKS; k++) mEn[k] = 0;
    end else begin
      mCs = 0; mMb = 0; mVs = 0;
      if (!mPrimed) begin
        mPrimed = 1; modelLoad(); mCs = 1;
      end else if (mPhase == 3) begin
        if (syncDone) begin
          mFrame = (mFrame + 1) % (1 << FRAME_W);
          mPhase = 0; mCnt = 0; modelLoad(); mCs = 1;
        end
      end else if (tick) begin
        int len;
        len = (mPhase == 0) ? mLc : (mPhase == 1) ? mLb : mLv;
        if (len == 0) len = 1;
        if (mCnt + 1 >= len) begin
          mMb = (mPhase == 0); mVs = (mPhase == 1);
          mPhase = mPhase + 1; mCnt = 0;
        end else mCnt = mCnt + 1;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(phase, mPhase, "R1 R5 phase");
      check(frameNum, mFrame, "R3 frameNum");
      check(computeStart, mCs, "R8 computeStart");
      check(mailboxLoad, mMb, "R8 mailboxLoad");
      check(voteStart, mVs, "R8 voteStart");
      check(resyncReq, mPhase == 3, "R5 resyncReq");
      check(cfgError, mErr, "R6 cfgError");
      for (int k = 0; k < NUM_TASKS; k++)
        check(taskEn[k], (mPhase == 0) && mEn[k], "R7 taskEn");
      if (taskEn[3] && cfgRates[15:12] == 4'd0) slot3Seen = 1;
    end
  end

  // random tick / syncDone source
  always @(negedge clk) begin
    syncDone <= ($urandom % 3) == 0;
    tick <= randTick ? (($urandom % 4) != 0) : 1'b1;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // count cycles of one compute phase entered from sync
  task automatic measureCompute(input int expLen, input int newLen, input bit change, input string tag);
    int cnt;
    do @(negedge clk); while (!(phase == 2'd0 && computeStart && frameNum != 0));
    cnt = 0;
    while (phase == 2'd0) begin
      cnt++;
      if (change && cnt == 2) cfgComputeLen = CNT_W'(newLen);
      @(negedge clk);
    end
    check(cnt, expLen, tag);
  endtask

  task automatic waitFrame(input int n);
    while (int'(frameNum) < n) @(negedge clk);
  endtask

  initial begin
    cfgComputeLen = 8'd3; cfgBcastLen = 8'd4; cfgVoteLen = 8'd2;
    cfgMaxDelay = 8'd2; cfgMaxSkew = 8'd1;
    cfgRates = {4'd0, 4'd3, 4'd2, 4'd1};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state before the first edge after release
    check(phase, 0, "R2 phase");
    check(frameNum, 0, "R2 frameNum");
    check({computeStart, mailboxLoad, voteStart, resyncReq, cfgError}, 0, "R2 strobes");
    check(taskEn, 0, "R2 taskEn");

    measureCompute(3, 0, 0, "R4 compute length");
    measureCompute(3, 6, 1, "R9 mid-compute change ignored");
    measureCompute(6, 0, 0, "R4 new compute length");
    waitFrame(14);
    check(slot3Seen, 0, "R10 zero-rate slot");

    // short broadcast window, zero compute length, new rates
    @(negedge clk);
    cfgComputeLen = 8'd0; cfgBcastLen = 8'd1; cfgMaxDelay = 8'd1; cfgMaxSkew = 8'd1;
    cfgRates = {4'd5, 4'd0, 4'd4, 4'd2};
    randTick = 1;
    waitFrame(16);
    @(negedge clk);
    check(cfgError, 1, "R6 window below bound");
    waitFrame(34);
    cfgBcastLen = 8'd2;
    waitFrame(36);
    @(negedge clk);
    check(cfgError, 0, "R6 window at bound");
    waitFrame(46);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule